// File: doc/BRIEF.md
# Programmable Delay and Gate Generator

This block turns the leading edge of an asynchronous input into one output pulse. The pulse starts a programmable number of system clock cycles after the edge and lasts a programmable number of cycles. The input first passes through a two-stage synchronizer. An edge detector then reduces each rising transition to a single-cycle trigger. Because of this, the output position relative to the raw input can vary by exactly one clock period.

A 32-bit control word holds both settings. The lower half sets the delay and the upper half sets the output width, both counted in clock cycles. The values are captured when a trigger is accepted, so rewriting the word while a pulse is in progress only changes the next pulse. An enable input returns the block to rest at once and drives the output low.

Top module: `pulse_delay_gate`

## Requirements
- R1: After reset, `pulse_out` is low and the block is at rest, waiting for a trigger.
- R2: If `trig_in` is first sampled high at clock edge E while enabled and at rest, `pulse_out` goes high after edge E+2+Deff and stays high for Weff cycles. Here Deff is the effective delay and Weff is the effective width, and 2 is the synchronizer depth.
- R3: The delay D is taken from `ctrl_word[15:0]`, and for D of 2 or more, Deff = D.
- R4: The width W is taken from `ctrl_word[31:16]`, and for W of 2 or more, Weff = W.
- R5: A programmed delay of 0 or 1 behaves as a delay of 2 (minimum internal delay).
- R6: A programmed width of 0 or 1 behaves as a width of 2, so the output is never high for only one cycle.
- R7: Rising edges of `trig_in` that arrive while the block is delaying or driving its pulse are ignored: no extra pulse is produced and the current pulse keeps its timing.
- R8: Only a low-to-high transition triggers. Holding `trig_in` high, even past the end of the pulse, produces exactly one pulse.
- R9: A change to `ctrl_word` while a pulse is in progress does not alter that pulse. The new values apply from the next accepted trigger.
- R10: While `enable` is low the block returns to rest on the next clock edge: `pulse_out` falls within one cycle and triggers are ignored.
- R11: Delay and width both accept values up to 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| enable | input | 1 | Block enable; low forces rest with output low |
| trig_in | input | 1 | Asynchronous trigger input |
| ctrl_word | input | 2*CNT_W (32) | [15:0] delay cycles, [31:16] width cycles |
| pulse_out | output | 1 | Delayed gate output |

## Verification
The bound checker checks the following on every cycle:
- an accepted trigger always enters the delay phase;
- a new delay phase lasts at least two cycles;
- the output never rises straight from rest and never lasts a single cycle;
- a trigger arriving during the delay does not reload the counter;
- a low enable clears the block on the next edge.

Only the bench scenarios can show the exact pulse start and pulse length that come from the control fields. The same holds for the effect of the synchronizer latency, for single-pulse behaviour under a held-high input, and for the deferred use of rewritten settings. The scoreboard compares measured start cycles and lengths against values computed from the requirements.

// File: rtl/dgg_pkg.sv
package dgg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_OUT   = 2'd2
    } dgg_state_e;

endpackage

// File: rtl/dgg_sync_edge.sv
module dgg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain    = {s_q.chain[LAST-1:0], async_in};
        s_d.prev     = s_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // single-cycle strobe on the synchronized rising transition
    assign rise = s_q.chain[LAST] & ~s_q.prev;

endmodule

// File: rtl/dgg_cfg_decode.sv
module dgg_cfg_decode #(
    parameter int CNT_W     = 16,
    parameter int MIN_DELAY = 2,
    parameter int MIN_WIDTH = 2
) (
    input  logic [2*CNT_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]   delay_load,
    output logic [CNT_W-1:0]   width_load
);
    localparam logic [CNT_W-1:0] MIN_D = CNT_W'(MIN_DELAY);
    localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_WIDTH);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] raw_delay;
    logic [CNT_W-1:0] raw_width;
    logic [CNT_W-1:0] eff_delay;
    logic [CNT_W-1:0] eff_width;

    always_comb begin
        raw_delay  = ctrl_word[CNT_W-1:0];
        raw_width  = ctrl_word[2*CNT_W-1:CNT_W];
        eff_delay  = (raw_delay < MIN_D) ? MIN_D : raw_delay;
        eff_width  = (raw_width < MIN_W) ? MIN_W : raw_width;
        // counters run down to zero inclusive, so load one less
        delay_load = eff_delay - ONE;
        width_load = eff_width - ONE;
    end

endmodule

// File: rtl/dgg_timer_fsm.sv
module dgg_timer_fsm
    import dgg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic [CNT_W-1:0] delay_load,
    input  logic [CNT_W-1:0] width_load,
    output dgg_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             gate
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        dgg_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wid;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_IDLE: begin
                if (trig) begin
                    f_d.st  = ST_DELAY;
                    f_d.cnt = delay_load;
                    f_d.wid = width_load;
                end
            end
            ST_DELAY: begin
                if (f_q.cnt == '0) begin
                    f_d.st  = ST_OUT;
                    f_d.cnt = f_q.wid;
                end else begin
                    f_d.cnt = f_q.cnt - ONE;
                end
            end
            ST_OUT: begin
                if (f_q.cnt == '0) begin
                    f_d.st = ST_IDLE;
                end else begin
                    f_d.cnt = f_q.cnt - ONE;
                end
            end
            default: begin
                f_d.st  = ST_IDLE;
                f_d.cnt = '0;
            end
        endcase
        if (!enable) begin
            f_d.st  = ST_IDLE;
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.st  <= ST_IDLE;
            f_q.cnt <= '0;
            f_q.wid <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state = f_q.st;
    assign cnt   = f_q.cnt;
    assign gate  = (f_q.st == ST_OUT);

endmodule

// File: rtl/pulse_delay_gate.sv
module pulse_delay_gate
    import dgg_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DELAY   = 2,
    parameter int MIN_WIDTH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               trig_in,
    input  logic [2*CNT_W-1:0] ctrl_word,
    output logic               pulse_out
);
    logic             trig_rise;
    logic [CNT_W-1:0] delay_load;
    logic [CNT_W-1:0] width_load;
    dgg_state_e       fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    dgg_sync_edge #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    dgg_cfg_decode #(
        .CNT_W      (CNT_W),
        .MIN_DELAY  (MIN_DELAY),
        .MIN_WIDTH  (MIN_WIDTH)
    ) u_cfg (
        .ctrl_word  (ctrl_word),
        .delay_load (delay_load),
        .width_load (width_load)
    );

    dgg_timer_fsm #(
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .trig       (trig_rise),
        .delay_load (delay_load),
        .width_load (width_load),
        .state      (fsm_state),
        .cnt        (fsm_cnt),
        .gate       (pulse_out)
    );

endmodule

// File: rtl/dgg_checker.sv
module dgg_checker
    import dgg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise,
    input  dgg_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pulse_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_TRIGGER_STARTS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rise && enable) |=> (state == ST_DELAY)); // R2

    AST_PULSE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> ($past(state) == ST_DELAY)); // R2

    AST_MIN_DELAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && $past(state) == ST_IDLE && enable) |=> (state == ST_DELAY)); // R5

    AST_MIN_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_out) && enable) |=> pulse_out); // R6

    AST_BUSY_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && rise && enable && cnt != '0)
        |=> (state == ST_DELAY && cnt == $past(cnt) - ONE)); // R7

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE && !pulse_out)); // R10

endmodule

bind pulse_delay_gate dgg_checker #(
    .CNT_W     (CNT_W)
) u_dgg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rise      (trig_rise),
    .state     (fsm_state),
    .cnt       (fsm_cnt),
    .pulse_out (pulse_out)
);

// File: tb/test_pulse_delay_gate.sv
module test_pulse_delay_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        trig_in = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        pulse_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int exp_start[$];
    int exp_len[$];
    string exp_tag[$];

    pulse_delay_gate i_pulse_delay_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .trig_in   (trig_in),
        .ctrl_word (ctrl_word),
        .pulse_out (pulse_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: program, raise trigger, record the expected pulse
    task automatic start_trig(input int d, input int w, input bit expect_it, input string tag);
        @(negedge clk);
        ctrl_word = {w[15:0], d[15:0]};
        trig_in   = 1'b1;
        if (expect_it) begin
            exp_start.push_back(cyc + 3 + eff(d));
            exp_len.push_back(eff(w));
            exp_tag.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int d, input int w, input int hold, input string tag);
        start_trig(d, w, 1'b1, tag);
        idle(hold);
        trig_in = 1'b0;
        idle(eff(d) + eff(w) + 8);
    endtask

    // monitor: measure each output pulse and compare against the queue
    int  mon_start = 0;
    bit  mon_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_out && !mon_prev) mon_start = cyc;
            if (!pulse_out && mon_prev) begin
                if (exp_start.size() == 0) begin
                    check(1'b0, "R7 unexpected pulse", mon_start, -1);
                end else begin
                    string t;
                    int    es;
                    int    el;
                    t  = exp_tag.pop_front();
                    es = exp_start.pop_front();
                    el = exp_len.pop_front();
                    check(mon_start == es, {t, " start"}, mon_start, es);
                    check(cyc - mon_start == el, {t, " width"}, cyc - mon_start, el);
                end
            end
            mon_prev = pulse_out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(pulse_out == 1'b0, "R1 reset output", pulse_out, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        idle(3);
        check(pulse_out == 1'b0, "R1 idle after reset", pulse_out, 0);

        // R2 R3 R4 basic timing, several settings
        fire(7, 3, 2, "R3 d7w3");
        fire(20, 9, 1, "R4 d20w9");
        fire(2, 2, 3, "R2 d2w2");
        // R5 delay floor
        fire(0, 5, 2, "R5 d0");
        fire(1, 5, 2, "R5 d1");
        // R6 width floor
        fire(4, 0, 2, "R6 w0");
        fire(4, 1, 2, "R6 w1");

        // R7 edges during delay and during output are ignored
        start_trig(12, 6, 1'b1, "R7 busy");
        idle(3); trig_in = 1'b0;
        idle(3); trig_in = 1'b1;   // edge while delaying
        idle(2); trig_in = 1'b0;
        idle(10); trig_in = 1'b1;  // edge while outputting
        idle(2); trig_in = 1'b0;
        idle(20);
        check(exp_start.size() == 0, "R7 queue drained", exp_start.size(), 0);

        // R8 held-high input gives one pulse
        start_trig(5, 4, 1'b1, "R8 held");
        idle(40);
        check(pulse_out == 1'b0, "R8 no retrigger while held", pulse_out, 0);
        trig_in = 1'b0;
        idle(10);

        // R9 reprogramming during a pulse applies only to the next one
        start_trig(10, 6, 1'b1, "R9 old values");
        idle(2); trig_in = 1'b0;
        idle(2); ctrl_word = {16'd20, 16'd3};
        idle(25);
        start_trig(3, 20, 1'b1, "R9 new values");
        idle(2); trig_in = 1'b0;
        idle(35);

        // R10 disable during delay aborts, triggers ignored while low
        start_trig(20, 5, 1'b0, "R10 abort");
        idle(2); trig_in = 1'b0;
        idle(6); enable = 1'b0;
        @(negedge clk);
        check(pulse_out == 1'b0, "R10 low after disable", pulse_out, 0);
        trig_in = 1'b1; idle(3); trig_in = 1'b0;
        idle(40);
        check(pulse_out == 1'b0, "R10 ignored while disabled", pulse_out, 0);
        enable = 1'b1;
        idle(5);

        // R10 disable during output truncates the pulse to 4 cycles
        start_trig(4, 30, 1'b0, "R10 trunc");
        idle(2); trig_in = 1'b0;
        while (!pulse_out) @(negedge clk);
        exp_start.push_back(cyc);
        exp_len.push_back(4);
        exp_tag.push_back("R10 truncate");
        idle(3); enable = 1'b0;
        @(negedge clk);
        check(pulse_out == 1'b0, "R10 output falls", pulse_out, 0);
        idle(5); enable = 1'b1;
        idle(5);

        // R11 full-scale values
        fire(65535, 3, 2, "R11 max delay");
        fire(3, 65535, 2, "R11 max width");

        check(exp_start.size() == 0, "R2 all pulses seen", exp_start.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule